// File: doc/BRIEF.md
# Port-Bound Micro-op Scheduler

This block is a unified scheduling window of twenty micro-op slots that feeds five execution ports. Two ports carry integer ALUs. The other three handle load address generation, store address generation and store data. Each micro-op is tied to exactly one port at the moment it is written into the window. From then on it competes only with the other entries tied to the same port. This turns the selection problem into five small, independent oldest-first pickers instead of one wide many-to-many matcher.

A micro-op enters with its kind, an opaque payload, and two source tags with readiness flags. Three result-tag buses broadcast completed producers each cycle and mark matching sources ready, including sources of a micro-op that is being written in that same cycle. A port that raises its busy input takes nothing that cycle. Entries bound to it wait, even when the sibling integer port is idle. A flush empties the whole window in one cycle.

Top module: `rs_sched`

## Requirements
- R1: After reset no port issues and `alloc_ready_o` is high.
- R2: Kind encoding on `alloc_kind_i` is 0 integer, 1 load, 2 store address, 3 store data. A load issues only on port 2, a store address only on port 3 and store data only on port 4. The payload appears on that port's `issue_uop_o` lane.
- R3: Integer micro-ops are bound alternately to port 0 and port 1, starting with port 0 after reset. The alternation advances once per accepted integer allocation.
- R4: A ready entry whose port has `port_busy_i` high does not issue, and it does not move to an idle sibling port. It issues in the same cycle the busy input drops.
- R5: Among ready entries bound to one port, the one allocated earliest issues first, regardless of slot position.
- R6: A source waiting on a tag becomes ready when any of the three wake buses carries that tag with its valid bit. The entry issues in the cycle after that broadcast. A broadcast of a different tag has no effect.
- R7: A source tag that matches a broadcast in the same cycle as its allocation is taken as ready, and the entry can issue in the next cycle.
- R8: Up to five micro-ops issue in one cycle, at most one per port.
- R9: An entry is freed at the clock edge that ends its issue cycle and never issues twice.
- R10: When all twenty slots are occupied, `alloc_ready_o` is low and a requested allocation is dropped. Readiness returns in the cycle after an entry issues.
- R11: While `flush_i` is high no port issues and any allocation that cycle is dropped. In the next cycle the window is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_i | input | 1 | Empty the window this cycle |
| alloc_valid_i | input | 1 | Allocation request |
| alloc_ready_o | output | 1 | At least one free slot |
| alloc_kind_i | input | 2 | Micro-op kind (0 int, 1 load, 2 store address, 3 store data) |
| alloc_uop_i | input | 8 | Opaque micro-op payload |
| alloc_src0_tag_i | input | 6 | First source tag |
| alloc_src0_rdy_i | input | 1 | First source already available |
| alloc_src1_tag_i | input | 6 | Second source tag |
| alloc_src1_rdy_i | input | 1 | Second source already available |
| wake_valid_i | input | 3 | Valid bit per wake bus |
| wake_tag_i | input | 3x6 | Result tag per wake bus |
| port_busy_i | input | 5 | Port cannot accept this cycle |
| issue_valid_o | output | 5 | Port issues this cycle |
| issue_uop_o | output | 5x8 | Payload per port |

## Verification
A corrupted age order would show at once as two same-port micro-ops leaving in the wrong order, or as two grants on one port in a single cycle. A stale valid bit would show in the following cycle as a repeated issue or a stuck-low `alloc_ready_o`. A wrong binding shows in the first issue cycle as the payload arriving on the wrong lane. A lost or spurious wakeup shifts the issue by at least one cycle against the broadcast, so every check samples the exact cycle derived from the register count between input and output.

// File: rtl/rs_pkg.sv
// Shared kinds and port numbering for the port-bound scheduler.
package rs_pkg;
    localparam int NUM_PORTS = 5;
    localparam int PORT_W    = 3;

    typedef enum logic [1:0] {
        KIND_INT  = 2'd0,
        KIND_LOAD = 2'd1,
        KIND_STA  = 2'd2,
        KIND_STD  = 2'd3
    } uop_kind_e;

    localparam logic [PORT_W-1:0] PORT_LOAD = 3'd2;
    localparam logic [PORT_W-1:0] PORT_STA  = 3'd3;
    localparam logic [PORT_W-1:0] PORT_STD  = 3'd4;
endpackage

// File: rtl/rs_port_binder.sv
// Maps a micro-op kind to its execution port.
// Integer work alternates between ports 0 and 1; the toggle advances only on
// an accepted integer allocation. Assumes accept_i is already qualified.
module rs_port_binder
    import rs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        kind_i,
    input  logic              accept_i,
    output logic [PORT_W-1:0] port_o
);
    logic alt_q;

    // Advance the integer alternation on each accepted integer micro-op.
    always_ff @(posedge clk) begin
        if (!rst_n)
            alt_q <= 1'b0;
        else if (accept_i && (kind_i == KIND_INT))
            alt_q <= ~alt_q;
    end

    // Decode kind into a port number.
    always_comb begin
        unique case (kind_i)
            KIND_INT:  port_o = {2'b00, alt_q};
            KIND_LOAD: port_o = PORT_LOAD;
            KIND_STA:  port_o = PORT_STA;
            default:   port_o = PORT_STD;
        endcase
    end

    // R3: consecutive accepted integer allocations never share a port.
    a_r3_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && kind_i == KIND_INT) |=> (kind_i != KIND_INT || port_o != $past(port_o)));
endmodule

// File: rtl/rs_age_matrix.sv
// Relative age between scheduler slots.
// older_o[i][j] set means slot j was allocated before slot i and is still live.
// A new slot takes the current live set as its row and is removed from every
// other row, so stale relations from freed slots never survive reuse.
module rs_age_matrix #(
    parameter int N = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                alloc_en_i,
    input  logic [N-1:0]        alloc_vec_i,
    input  logic [N-1:0]        live_i,
    output logic [N-1:0][N-1:0] older_o
);
    // Update rows on allocation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            older_o <= '0;
        end else if (alloc_en_i) begin
            for (int i = 0; i < N; i++) begin
                if (alloc_vec_i[i])
                    older_o[i] <= live_i;
                else
                    older_o[i] <= older_o[i] & ~alloc_vec_i;
            end
        end
    end

    // R5: two live slots are never each older than the other.
    always_ff @(posedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < N; i++)
                for (int j = 0; j < N; j++)
                    a_r5_age_order: assert (!(live_i[i] && live_i[j] && older_o[i][j] && older_o[j][i]));
        end
    end
endmodule

// File: rtl/rs_oldest_picker.sv
// One-of-N oldest-first selector for a single port.
// Assumes older_i is a strict order over the requesting slots.
module rs_oldest_picker #(
    parameter int N = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        req_i,
    input  logic [N-1:0][N-1:0] older_i,
    output logic [N-1:0]        grant_o,
    output logic                any_o
);
    // A requester wins when no older slot also requests.
    always_comb begin
        for (int i = 0; i < N; i++)
            grant_o[i] = req_i[i] && ((req_i & older_i[i]) == '0);
        any_o = |grant_o;
    end

    // R8: a port grants at most one slot per cycle.
    a_r8_one_per_port: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant_o));

    // R5: any request yields a grant.
    a_r5_no_starve: assert property (@(posedge clk) disable iff (!rst_n) (|req_i) |-> any_o);
endmodule

// File: rtl/rs_sched.sv
// Unified scheduling window with per-port binding and oldest-first pick.
// Holds N_ENTRIES micro-ops. Each is bound to one port when written, woken by
// N_WAKE result-tag buses, and issued combinationally when its port is free.
// Issue outputs are valid within the cycle; the slot is freed at the closing edge.
module rs_sched
    import rs_pkg::*;
#(
    parameter int N_ENTRIES = 20,
    parameter int UOP_W     = 8,
    parameter int TAG_W     = 6,
    parameter int N_WAKE    = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              flush_i,
    input  logic                              alloc_valid_i,
    output logic                              alloc_ready_o,
    input  logic [1:0]                        alloc_kind_i,
    input  logic [UOP_W-1:0]                  alloc_uop_i,
    input  logic [TAG_W-1:0]                  alloc_src0_tag_i,
    input  logic                              alloc_src0_rdy_i,
    input  logic [TAG_W-1:0]                  alloc_src1_tag_i,
    input  logic                              alloc_src1_rdy_i,
    input  logic [N_WAKE-1:0]                 wake_valid_i,
    input  logic [N_WAKE-1:0][TAG_W-1:0]      wake_tag_i,
    input  logic [NUM_PORTS-1:0]              port_busy_i,
    output logic [NUM_PORTS-1:0]              issue_valid_o,
    output logic [NUM_PORTS-1:0][UOP_W-1:0]   issue_uop_o
);
    localparam int N = N_ENTRIES;

    logic [N-1:0]              ent_valid;
    logic [N-1:0][PORT_W-1:0]  ent_port;
    logic [N-1:0][UOP_W-1:0]   ent_uop;
    logic [N-1:0][TAG_W-1:0]   ent_tag0;
    logic [N-1:0][TAG_W-1:0]   ent_tag1;
    logic [N-1:0]              ent_rdy0;
    logic [N-1:0]              ent_rdy1;

    logic [N-1:0]                 alloc_vec;
    logic                         alloc_fire;
    logic [PORT_W-1:0]            alloc_port;
    logic [N-1:0]                 issued;
    logic [N-1:0]                 live;
    logic [N-1:0][N-1:0]          older;
    logic [NUM_PORTS-1:0][N-1:0]  grant;

    // True when any valid wake bus carries the given tag.
    function automatic logic tag_hit(input logic [TAG_W-1:0] tag,
                                     input logic [N_WAKE-1:0] wv,
                                     input logic [N_WAKE-1:0][TAG_W-1:0] wt);
        logic hit;
        hit = 1'b0;
        for (int w = 0; w < N_WAKE; w++)
            hit |= wv[w] && (wt[w] == tag);
        return hit;
    endfunction

    // Lowest free slot receives the next allocation.
    always_comb begin
        alloc_vec = '0;
        for (int i = N - 1; i >= 0; i--)
            if (!ent_valid[i]) alloc_vec = N'(1) << i;
    end

    assign alloc_ready_o = ~&ent_valid;
    assign alloc_fire    = alloc_valid_i && alloc_ready_o && !flush_i;

    rs_port_binder u_binder (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind_i   (alloc_kind_i),
        .accept_i (alloc_fire),
        .port_o   (alloc_port)
    );

    rs_age_matrix #(.N(N)) u_age (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_en_i  (alloc_fire),
        .alloc_vec_i (alloc_vec),
        .live_i      (live),
        .older_o     (older)
    );

    // One picker per port over the slots bound to it.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic [N-1:0]     req;
        logic             any;
        logic [UOP_W-1:0] uop_sel;

        // Build the request vector for this port.
        always_comb begin
            for (int i = 0; i < N; i++)
                req[i] = ent_valid[i] && ent_rdy0[i] && ent_rdy1[i]
                         && (ent_port[i] == PORT_W'(p))
                         && !port_busy_i[p] && !flush_i;
        end

        rs_oldest_picker #(.N(N)) u_pick (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_i   (req),
            .older_i (older),
            .grant_o (grant[p]),
            .any_o   (any)
        );

        // Route the winning payload to this port.
        always_comb begin
            uop_sel = '0;
            for (int i = 0; i < N; i++)
                if (grant[p][i]) uop_sel |= ent_uop[i];
        end

        assign issue_valid_o[p] = any;
        assign issue_uop_o[p]   = uop_sel;

        // R4: a busy port never issues.
        a_r4_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
            port_busy_i[p] |-> !issue_valid_o[p]);
    end

    // Collect slots leaving this cycle.
    always_comb begin
        issued = '0;
        for (int p = 0; p < NUM_PORTS; p++)
            issued |= grant[p];
    end

    assign live = ent_valid & ~issued;

    // Slot state: allocate, wake, free, flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= '0;
            ent_port  <= '0;
            ent_uop   <= '0;
            ent_tag0  <= '0;
            ent_tag1  <= '0;
            ent_rdy0  <= '0;
            ent_rdy1  <= '0;
        end else if (flush_i) begin
            ent_valid <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (alloc_fire && alloc_vec[i]) begin
                    ent_valid[i] <= 1'b1;
                    ent_port[i]  <= alloc_port;
                    ent_uop[i]   <= alloc_uop_i;
                    ent_tag0[i]  <= alloc_src0_tag_i;
                    ent_tag1[i]  <= alloc_src1_tag_i;
                    ent_rdy0[i]  <= alloc_src0_rdy_i || tag_hit(alloc_src0_tag_i, wake_valid_i, wake_tag_i);
                    ent_rdy1[i]  <= alloc_src1_rdy_i || tag_hit(alloc_src1_tag_i, wake_valid_i, wake_tag_i);
                end else begin
                    if (issued[i]) ent_valid[i] <= 1'b0;
                    if (ent_valid[i]) begin
                        ent_rdy0[i] <= ent_rdy0[i] || tag_hit(ent_tag0[i], wake_valid_i, wake_tag_i);
                        ent_rdy1[i] <= ent_rdy1[i] || tag_hit(ent_tag1[i], wake_valid_i, wake_tag_i);
                    end
                end
            end
        end
    end

    // R9: a slot granted this cycle is empty in the next.
    for (genvar e = 0; e < N; e++) begin : g_free_chk
        a_r9_freed: assert property (@(posedge clk) disable iff (!rst_n)
            issued[e] |=> !ent_valid[e]);
    end

    // R11: nothing issues in the cycle after a flush.
    a_r11_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (issue_valid_o == '0));

    // R10: with the window full and nothing leaving, it stays full.
    a_r10_stay_full: assert property (@(posedge clk) disable iff (!rst_n)
        (!alloc_ready_o && !flush_i && (issued == '0)) |=> !alloc_ready_o);
endmodule

// File: tb/sim_rs_sched.sv
// Directed bench for rs_sched: one task per scenario, each checking its own results.
module sim_rs_sched;
    logic              clk = 1'b0;
    logic              rst_n;
    logic              flush_i;
    logic              alloc_valid_i;
    logic              alloc_ready_o;
    logic [1:0]        alloc_kind_i;
    logic [7:0]        alloc_uop_i;
    logic [5:0]        alloc_src0_tag_i;
    logic              alloc_src0_rdy_i;
    logic [5:0]        alloc_src1_tag_i;
    logic              alloc_src1_rdy_i;
    logic [2:0]        wake_valid_i;
    logic [2:0][5:0]   wake_tag_i;
    logic [4:0]        port_busy_i;
    logic [4:0]        issue_valid_o;
    logic [4:0][7:0]   issue_uop_o;

    int checks = 0;
    int errors = 0;
    logic exp_alt = 1'b0;

    always #2 clk = ~clk;

    rs_sched u0 (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Present one allocation for one edge, then withdraw it.
    task automatic alloc(input logic [1:0] kind, input logic [7:0] uop,
                         input logic [5:0] t0, input logic r0,
                         input logic [5:0] t1, input logic r1);
        alloc_valid_i = 1'b1; alloc_kind_i = kind; alloc_uop_i = uop;
        alloc_src0_tag_i = t0; alloc_src0_rdy_i = r0;
        alloc_src1_tag_i = t1; alloc_src1_rdy_i = r1;
        step();
        alloc_valid_i = 1'b0;
    endtask

    task automatic alloc_int(input logic [7:0] uop, output int port);
        port = exp_alt ? 1 : 0;
        exp_alt = ~exp_alt;
        alloc(2'd0, uop, 6'd0, 1'b1, 6'd0, 1'b1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; flush_i = 1'b0; alloc_valid_i = 1'b0; alloc_kind_i = '0;
        alloc_uop_i = '0; alloc_src0_tag_i = '0; alloc_src0_rdy_i = 1'b0;
        alloc_src1_tag_i = '0; alloc_src1_rdy_i = 1'b0; wake_valid_i = '0;
        wake_tag_i = '0; port_busy_i = '0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        check("R1 issue idle", 32'(issue_valid_o), 0);
        check("R1 ready", 32'(alloc_ready_o), 1);
    endtask

    task automatic t_kinds();
        alloc(2'd1, 8'h21, 6'd0, 1'b1, 6'd0, 1'b1);
        check("R2 load port", 32'(issue_valid_o), 32'b00100);
        check("R2 load uop", 32'(issue_uop_o[2]), 32'h21);
        alloc(2'd2, 8'h22, 6'd0, 1'b1, 6'd0, 1'b1);
        check("R2 sta port", 32'(issue_valid_o), 32'b01000);
        check("R2 sta uop", 32'(issue_uop_o[3]), 32'h22);
        alloc(2'd3, 8'h23, 6'd0, 1'b1, 6'd0, 1'b1);
        check("R2 std port", 32'(issue_valid_o), 32'b10000);
        check("R2 std uop", 32'(issue_uop_o[4]), 32'h23);
        step();
    endtask

    task automatic t_alternate();
        int p;
        alloc_int(8'h31, p);
        check("R3 first int port0", 32'(issue_valid_o), 32'b00001);
        check("R3 first int uop", 32'(issue_uop_o[0]), 32'h31);
        alloc_int(8'h32, p);
        check("R3 second int port1", 32'(issue_valid_o), 32'b00010);
        check("R3 second int uop", 32'(issue_uop_o[1]), 32'h32);
        step();
    endtask

    task automatic t_busy();
        int p;
        port_busy_i = 5'b00001;
        alloc_int(8'h41, p);
        check("R4 bound port index", 32'(p), 0);
        check("R4 waits, no migration", 32'(issue_valid_o), 0);
        step();
        check("R4 still waits", 32'(issue_valid_o), 0);
        port_busy_i = '0;
        #1;
        check("R4 issues on release", 32'(issue_valid_o), 32'b00001);
        check("R4 uop", 32'(issue_uop_o[0]), 32'h41);
        step();
        check("R9 no repeat", 32'(issue_valid_o), 0);
    endtask

    task automatic t_wakeup();
        alloc(2'd1, 8'h51, 6'd5, 1'b0, 6'd7, 1'b1);
        check("R6 waits on source", 32'(issue_valid_o), 0);
        wake_valid_i = 3'b001; wake_tag_i[0] = 6'd6;
        step();
        wake_valid_i = '0;
        check("R6 mismatched tag ignored", 32'(issue_valid_o), 0);
        wake_valid_i = 3'b100; wake_tag_i[2] = 6'd5;
        step();
        wake_valid_i = '0;
        check("R6 issues after wake", 32'(issue_valid_o), 32'b00100);
        check("R6 uop", 32'(issue_uop_o[2]), 32'h51);
        step();
        check("R9 freed", 32'(issue_valid_o), 0);
        wake_valid_i = 3'b010; wake_tag_i[1] = 6'd9;
        alloc(2'd1, 8'h52, 6'd9, 1'b0, 6'd9, 1'b0);
        wake_valid_i = '0;
        check("R7 bypass wake", 32'(issue_valid_o), 32'b00100);
        check("R7 uop", 32'(issue_uop_o[2]), 32'h52);
        step();
    endtask

    task automatic t_all_ports();
        int pa, pb;
        port_busy_i = 5'b11111;
        alloc_int(8'h61, pa);
        alloc_int(8'h62, pb);
        alloc(2'd1, 8'h63, 6'd0, 1'b1, 6'd0, 1'b1);
        alloc(2'd2, 8'h64, 6'd0, 1'b1, 6'd0, 1'b1);
        alloc(2'd3, 8'h65, 6'd0, 1'b1, 6'd0, 1'b1);
        check("R8 held while busy", 32'(issue_valid_o), 0);
        port_busy_i = '0;
        #1;
        check("R8 five issue", 32'(issue_valid_o), 32'b11111);
        check("R8 int a", 32'(issue_uop_o[pa]), 32'h61);
        check("R8 int b", 32'(issue_uop_o[pb]), 32'h62);
        check("R8 load", 32'(issue_uop_o[2]), 32'h63);
        check("R8 sta", 32'(issue_uop_o[3]), 32'h64);
        check("R8 std", 32'(issue_uop_o[4]), 32'h65);
        step();
        check("R9 all freed", 32'(issue_valid_o), 0);
    endtask

    task automatic t_age();
        port_busy_i = 5'b01100;
        alloc(2'd2, 8'h71, 6'd0, 1'b1, 6'd0, 1'b1);
        alloc(2'd1, 8'h72, 6'd0, 1'b1, 6'd0, 1'b1);
        port_busy_i = 5'b00100;
        step();
        check("R5 store gone", 32'(issue_valid_o), 0);
        alloc(2'd1, 8'h73, 6'd0, 1'b1, 6'd0, 1'b1);
        port_busy_i = '0;
        #1;
        check("R5 oldest first", 32'(issue_uop_o[2]), 32'h72);
        step();
        check("R5 younger next", 32'(issue_uop_o[2]), 32'h73);
        check("R5 younger valid", 32'(issue_valid_o), 32'b00100);
        step();
        check("R5 drained", 32'(issue_valid_o), 0);
    endtask

    task automatic t_full_flush();
        port_busy_i = 5'b11111;
        for (int i = 0; i < 20; i++)
            alloc(2'd3, 8'(i), 6'd0, 1'b1, 6'd0, 1'b1);
        check("R10 full", 32'(alloc_ready_o), 0);
        alloc(2'd2, 8'h99, 6'd0, 1'b1, 6'd0, 1'b1);
        port_busy_i = 5'b10111;
        #1;
        check("R10 dropped alloc", 32'(issue_valid_o[3]), 0);
        step();
        check("R10 still dropped", 32'(issue_valid_o[3]), 0);
        port_busy_i = 5'b01111;
        #1;
        check("R10 oldest store data", 32'(issue_valid_o), 32'b10000);
        check("R10 oldest uop", 32'(issue_uop_o[4]), 0);
        step();
        port_busy_i = 5'b11111;
        check("R10 ready again", 32'(alloc_ready_o), 1);
        port_busy_i = '0;
        flush_i = 1'b1;
        alloc_valid_i = 1'b1; alloc_kind_i = 2'd1; alloc_uop_i = 8'h88;
        alloc_src0_rdy_i = 1'b1; alloc_src1_rdy_i = 1'b1;
        #1;
        check("R11 no issue during flush", 32'(issue_valid_o), 0);
        step();
        flush_i = 1'b0; alloc_valid_i = 1'b0;
        #1;
        check("R11 empty after flush", 32'(issue_valid_o), 0);
        check("R11 ready after flush", 32'(alloc_ready_o), 1);
        step();
        check("R11 alloc dropped", 32'(issue_valid_o), 0);
    endtask

    initial begin
        t_reset();
        t_kinds();
        t_alternate();
        t_busy();
        t_wakeup();
        t_all_ports();
        t_age();
        t_full_flush();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule